// File: doc/BRIEF.md
# Context-Extended Microcode Line Cache

This block is a direct-mapped store of microcode words. Fetch logic presents an instruction address each cycle. The block joins that address with its own context value to form a lookup key. If the addressed line holds that key and is marked valid, the block returns the line's 64-bit payload as the microcode word to run in place of the instruction at that address. If the line does not match, the block flags a miss and returns the fixed handler address from which the fetch logic must continue.

The context value is a small register inside the block. It clears to zero on reset, and microcode can load it through a write port. One instruction address can therefore own several cached words, one for each context value. This serves multi-step operations and customised code paths. A refill port writes the payload and the valid bit of one line in a single cycle. The line is named by the address and context it will answer to. The reference depth is 64K lines; the default parameters use a small depth for simulation.

Top module: `mcode_cache`

## Requirements
- R1: After reset, `cr_o` is 0, `rsp_valid` is 0, and every line is invalid, so the first lookup of any address misses.
- R2: A request taken at a rising edge yields `rsp_valid`=1 at the next edge, with `rsp_hit`=1 and `rsp_word` equal to the stored payload when the line matches.
- R3: On a miss, `rsp_miss`=1, `rsp_hit`=0, `rsp_word`=0 and `rsp_target_ip` equals the `HANDLER_IP` parameter (default 16'h0F00). On a hit, `rsp_target_ip` is 0. `rsp_hit` and `rsp_miss` are never both 1.
- R4: The key is {`req_ip`, `cr_o`} with the context in the low `CR_W` bits. The low `IDX_W` key bits select the line and the remaining upper bits form the stored tag. The same address under different contexts returns different words.
- R5: Two keys that share an index but differ in the upper bits alias to one line. A lookup whose tag differs from the stored tag misses, and a refill of one key evicts the other.
- R6: A refill with `refill_keep`=0 marks the line invalid, so a later lookup of its key misses.
- R7: When a refill and a request address the same line at the same edge, the response reflects the newly written tag, payload and valid bit.
- R8: A context write at an edge sets `cr_o` to `cr_wdata` after that edge. A request at the same edge still uses the old context, and a request at any later edge uses the new one.
- R9: In a cycle that follows an edge with no request, `rsp_valid`, `rsp_hit` and `rsp_miss` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ip | input | IP_W | Instruction address to look up |
| cr_we | input | 1 | Context register write enable |
| cr_wdata | input | CR_W | New context value |
| cr_o | output | CR_W | Current context value |
| refill_en | input | 1 | Refill write strobe |
| refill_ip | input | IP_W | Address part of the key being written |
| refill_cr | input | CR_W | Context part of the key being written |
| refill_word | input | DATA_W | Microcode payload to store |
| refill_keep | input | 1 | Valid bit stored with the line |
| rsp_valid | output | 1 | Response present (one cycle after a request) |
| rsp_hit | output | 1 | Lookup matched a valid line |
| rsp_miss | output | 1 | Lookup did not match |
| rsp_word | output | DATA_W | Microcode word on a hit, zero otherwise |
| rsp_target_ip | output | IP_W | Handler address on a miss, zero otherwise |

## Verification
The hardest case to reach is a refill and a lookup landing on the same line at the same edge. The block RAM then returns the old contents, and only the bypass path can give the correct answer. The bench drives both strobes in the same half-cycle, once with the same key (expecting a hit on the new word) and once with an aliasing key (expecting a miss). Aliasing keys come from addresses that differ only above the index bits, and the old-context rule is tested by writing the context and issuing a lookup in one cycle.

// File: rtl/mcode_cache_pkg.sv
package mcode_cache_pkg;

  // Classification of the registered lookup result
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_MISS = 2'd2
  } rsp_kind_e;

endpackage

// File: rtl/mcode_cache_ctx.sv
// Context register: clears to zero, loaded by microcode.
module mcode_cache_ctx #(
  parameter int CR_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [CR_W-1:0] wdata,
  output logic [CR_W-1:0] value
);

  logic [CR_W-1:0] cr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q <= '0;
    end else if (we) begin
      cr_q <= wdata;
    end
  end

  assign value = cr_q;

endmodule

// File: rtl/mcode_cache_store.sv
// Line storage: tag+payload in an inferable RAM, valid bits in flops,
// plus a one-entry bypass for a write that collides with a read.
module mcode_cache_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_vld,
  output logic [TAG_W-1:0]  line_tag,
  output logic [DATA_W-1:0] line_data,
  output logic              line_vld
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int LINE_W = TAG_W + DATA_W;

  logic [LINE_W-1:0] mem [DEPTH];
  logic [LINE_W-1:0] rd_q;
  logic [LINE_W-1:0] byp_line_q;
  logic              byp_q;
  logic [DEPTH-1:0]  vld_arr;
  logic              vld_q;
  logic              collide;

  assign collide = rd_en && wr_en && (rd_idx == wr_idx);

  // RAM port: no reset so it maps onto block memory
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= {wr_tag, wr_data};
    end
    if (rd_en) begin
      rd_q <= mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    byp_line_q <= {wr_tag, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
    end else begin
      byp_q <= collide;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_arr <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        vld_arr[wr_idx] <= wr_vld;
      end
      if (rd_en) begin
        vld_q <= collide ? wr_vld : vld_arr[rd_idx];
      end
    end
  end

  logic [LINE_W-1:0] line_sel;
  assign line_sel  = byp_q ? byp_line_q : rd_q;
  assign line_tag  = line_sel[LINE_W-1:DATA_W];
  assign line_data = line_sel[DATA_W-1:0];
  assign line_vld  = vld_q;

endmodule

// File: rtl/mcode_cache_match.sv
// Tag comparison and response shaping for the registered lookup.
module mcode_cache_match
  import mcode_cache_pkg::*;
#(
  parameter int              TAG_W      = 16,
  parameter int              DATA_W     = 64,
  parameter int              IP_W       = 16,
  parameter logic [IP_W-1:0] HANDLER_IP = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              line_vld,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_word,
  output logic [IP_W-1:0]   rsp_target_ip
);

  logic             pend_q;
  logic [TAG_W-1:0] tag_q;
  rsp_kind_e        kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      tag_q <= req_tag;
    end
  end

  always_comb begin
    if (!pend_q) begin
      kind = RSP_IDLE;
    end else if (line_vld && (line_tag == tag_q)) begin
      kind = RSP_HIT;
    end else begin
      kind = RSP_MISS;
    end
  end

  assign rsp_valid     = (kind != RSP_IDLE);
  assign rsp_hit       = (kind == RSP_HIT);
  assign rsp_miss      = (kind == RSP_MISS);
  assign rsp_word      = (kind == RSP_HIT) ? line_data : '0;
  assign rsp_target_ip = (kind == RSP_MISS) ? HANDLER_IP : '0;

endmodule

// File: rtl/mcode_cache.sv
// Direct-mapped microcode cache keyed by {instruction address, context}.
module mcode_cache #(
  parameter int              IP_W       = 16,
  parameter int              CR_W       = 4,
  parameter int              IDX_W      = 6,
  parameter int              TAG_W      = 16,
  parameter int              DATA_W     = 64,
  parameter logic [IP_W-1:0] HANDLER_IP = 16'h0F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IP_W-1:0]   req_ip,
  input  logic              cr_we,
  input  logic [CR_W-1:0]   cr_wdata,
  output logic [CR_W-1:0]   cr_o,
  input  logic              refill_en,
  input  logic [IP_W-1:0]   refill_ip,
  input  logic [CR_W-1:0]   refill_cr,
  input  logic [DATA_W-1:0] refill_word,
  input  logic              refill_keep,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_word,
  output logic [IP_W-1:0]   rsp_target_ip
);

  localparam int KEY_W = IP_W + CR_W;

  logic [KEY_W-1:0] rd_key;
  logic [KEY_W-1:0] wr_key;
  logic [TAG_W-1:0] rd_tag;
  logic [TAG_W-1:0] wr_tag;
  logic [TAG_W-1:0] line_tag;
  logic [DATA_W-1:0] line_data;
  logic              line_vld;
  logic [CR_W-1:0]   cr_cur;

  assign rd_key = {req_ip, cr_cur};
  assign wr_key = {refill_ip, refill_cr};
  assign rd_tag = TAG_W'(rd_key >> IDX_W);
  assign wr_tag = TAG_W'(wr_key >> IDX_W);
  assign cr_o   = cr_cur;

  mcode_cache_ctx #(.CR_W(CR_W)) u_ctx (
    .clk   (clk),
    .rst   (rst),
    .we    (cr_we),
    .wdata (cr_wdata),
    .value (cr_cur)
  );

  mcode_cache_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (req_valid),
    .rd_idx   (rd_key[IDX_W-1:0]),
    .wr_en    (refill_en),
    .wr_idx   (wr_key[IDX_W-1:0]),
    .wr_tag   (wr_tag),
    .wr_data  (refill_word),
    .wr_vld   (refill_keep),
    .line_tag (line_tag),
    .line_data(line_data),
    .line_vld (line_vld)
  );

  mcode_cache_match #(
    .TAG_W     (TAG_W),
    .DATA_W    (DATA_W),
    .IP_W      (IP_W),
    .HANDLER_IP(HANDLER_IP)
  ) u_match (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_tag      (rd_tag),
    .line_tag     (line_tag),
    .line_data    (line_data),
    .line_vld     (line_vld),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_word     (rsp_word),
    .rsp_target_ip(rsp_target_ip)
  );

endmodule

// File: rtl/mcode_cache_chk.sv
// Port-level checker bound to the cache top.
module mcode_cache_chk #(
  parameter int              IP_W       = 16,
  parameter int              CR_W       = 4,
  parameter int              IDX_W      = 6,
  parameter int              DATA_W     = 64,
  parameter logic [IP_W-1:0] HANDLER_IP = 16'h0F00
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [IP_W-1:0]   req_ip,
  input logic              cr_we,
  input logic [CR_W-1:0]   cr_wdata,
  input logic [CR_W-1:0]   cr_o,
  input logic              refill_en,
  input logic [IP_W-1:0]   refill_ip,
  input logic [CR_W-1:0]   refill_cr,
  input logic [DATA_W-1:0] refill_word,
  input logic              refill_keep,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [DATA_W-1:0] rsp_word,
  input logic [IP_W-1:0]   rsp_target_ip
);

  localparam int KEY_W = IP_W + CR_W;

  logic [KEY_W-1:0] req_key;
  logic [KEY_W-1:0] fill_key;
  logic             same_key;
  logic             same_line;

  assign req_key   = {req_ip, cr_o};
  assign fill_key  = {refill_ip, refill_cr};
  assign same_key  = req_valid && refill_en && (req_key == fill_key);
  assign same_line = req_valid && refill_en &&
                     (req_key[IDX_W-1:0] == fill_key[IDX_W-1:0]);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss)); // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss}) == 1)); // R3

  AST_MISS_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_target_ip == HANDLER_IP && rsp_word == '0)); // R3

  AST_CTX_LOAD: assert property (@(posedge clk) disable iff (rst)
    cr_we |=> (cr_o == $past(cr_wdata))); // R8

  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cr_we |=> $stable(cr_o)); // R8

  AST_FILL_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (same_key && refill_keep) |=> (rsp_hit && rsp_word == $past(refill_word))); // R7

  AST_FILL_KILL: assert property (@(posedge clk) disable iff (rst)
    (same_line && !refill_keep) |=> rsp_miss); // R6

endmodule

bind mcode_cache mcode_cache_chk #(
  .IP_W      (IP_W),
  .CR_W      (CR_W),
  .IDX_W     (IDX_W),
  .DATA_W    (DATA_W),
  .HANDLER_IP(HANDLER_IP)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ip       (req_ip),
  .cr_we        (cr_we),
  .cr_wdata     (cr_wdata),
  .cr_o         (cr_o),
  .refill_en    (refill_en),
  .refill_ip    (refill_ip),
  .refill_cr    (refill_cr),
  .refill_word  (refill_word),
  .refill_keep  (refill_keep),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_word     (rsp_word),
  .rsp_target_ip(rsp_target_ip)
);

// File: tb/tb_mcode_cache.sv
module tb_mcode_cache;

  localparam int              IP_W    = 16;
  localparam int              CR_W    = 4;
  localparam int              DATA_W  = 64;
  localparam logic [IP_W-1:0] HANDLER = 16'h0F00;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [IP_W-1:0]   req_ip;
  logic              cr_we;
  logic [CR_W-1:0]   cr_wdata;
  logic [CR_W-1:0]   cr_o;
  logic              refill_en;
  logic [IP_W-1:0]   refill_ip;
  logic [CR_W-1:0]   refill_cr;
  logic [DATA_W-1:0] refill_word;
  logic              refill_keep;
  logic              rsp_valid;
  logic              rsp_hit;
  logic              rsp_miss;
  logic [DATA_W-1:0] rsp_word;
  logic [IP_W-1:0]   rsp_target_ip;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mcode_cache dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ip(req_ip),
    .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_o(cr_o),
    .refill_en(refill_en), .refill_ip(refill_ip), .refill_cr(refill_cr),
    .refill_word(refill_word), .refill_keep(refill_keep),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_word(rsp_word), .rsp_target_ip(rsp_target_ip)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Check a full response: hit with word, or miss to the handler
  task automatic expect_rsp(string req, bit hit, logic [63:0] word);
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " hit"}, 64'(rsp_hit), 64'(hit));
    check({req, " miss"}, 64'(rsp_miss), 64'(!hit));
    check({req, " word"}, rsp_word, hit ? word : 64'd0);
    check({req, " target"}, 64'(rsp_target_ip), hit ? 64'd0 : 64'(HANDLER));
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic lookup(logic [IP_W-1:0] ip);
    req_valid = 1'b1; req_ip = ip;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(logic [IP_W-1:0] ip, logic [CR_W-1:0] cr,
                      logic [63:0] w, bit keep);
    refill_en = 1'b1; refill_ip = ip; refill_cr = cr;
    refill_word = w; refill_keep = keep;
    @(negedge clk);
    refill_en = 1'b0;
  endtask

  task automatic set_ctx(logic [CR_W-1:0] v);
    cr_we = 1'b1; cr_wdata = v;
    @(negedge clk);
    cr_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cr after reset", 64'(cr_o), 64'd0);
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    lookup(16'h0010);
    expect_rsp("R1/R3 cold lookup misses", 1'b0, 64'd0);
  endtask

  task automatic t_hit();
    fill(16'h0010, 4'd0, 64'hA0A0_1111_2222_3333, 1'b1);
    lookup(16'h0010);
    expect_rsp("R2 hit after refill", 1'b1, 64'hA0A0_1111_2222_3333);
    @(negedge clk);
    check("R9 idle valid", 64'(rsp_valid), 64'd0);
    check("R9 idle hit/miss", 64'({rsp_hit, rsp_miss}), 64'd0);
  endtask

  task automatic t_context();
    fill(16'h0010, 4'd1, 64'hB0B0_4444_5555_6666, 1'b1);
    lookup(16'h0010);
    expect_rsp("R4 ctx0 word", 1'b1, 64'hA0A0_1111_2222_3333);
    set_ctx(4'd1);
    check("R8 cr loaded", 64'(cr_o), 64'd1);
    lookup(16'h0010);
    expect_rsp("R4 ctx1 word", 1'b1, 64'hB0B0_4444_5555_6666);
    // context write and lookup at the same edge: old context applies
    cr_we = 1'b1; cr_wdata = 4'd2;
    req_valid = 1'b1; req_ip = 16'h0010;
    @(negedge clk);
    cr_we = 1'b0; req_valid = 1'b0;
    expect_rsp("R8 same-edge uses old ctx", 1'b1, 64'hB0B0_4444_5555_6666);
    check("R8 cr after same-edge write", 64'(cr_o), 64'd2);
    lookup(16'h0010);
    expect_rsp("R8 new ctx 2 misses", 1'b0, 64'd0);
    set_ctx(4'd0);
  endtask

  task automatic t_alias();
    // 0x0014 and 0x0010 share index 0 under ctx 0, tags 5 vs 4
    lookup(16'h0014);
    expect_rsp("R5 alias misses", 1'b0, 64'd0);
    fill(16'h0014, 4'd0, 64'hC0C0_7777_8888_9999, 1'b1);
    lookup(16'h0014);
    expect_rsp("R5 alias hit after fill", 1'b1, 64'hC0C0_7777_8888_9999);
    lookup(16'h0010);
    expect_rsp("R5 evicted key misses", 1'b0, 64'd0);
  endtask

  task automatic t_invalidate();
    fill(16'h0014, 4'd0, 64'hDEAD_0000_0000_0001, 1'b0);
    lookup(16'h0014);
    expect_rsp("R6 invalidated line misses", 1'b0, 64'd0);
  endtask

  task automatic t_bypass();
    // same key in the same cycle
    req_valid = 1'b1; req_ip = 16'h0020;
    refill_en = 1'b1; refill_ip = 16'h0020; refill_cr = 4'd0;
    refill_word = 64'hD0D0_ABCD_EF01_2345; refill_keep = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; refill_en = 1'b0;
    expect_rsp("R7 same-key bypass hit", 1'b1, 64'hD0D0_ABCD_EF01_2345);
    // aliasing key written in the same cycle as a lookup
    req_valid = 1'b1; req_ip = 16'h0020;
    refill_en = 1'b1; refill_ip = 16'h0024; refill_cr = 4'd0;
    refill_word = 64'hE0E0_1357_9BDF_0246; refill_keep = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; refill_en = 1'b0;
    expect_rsp("R7 alias bypass miss", 1'b0, 64'd0);
    lookup(16'h0024);
    expect_rsp("R7 alias written", 1'b1, 64'hE0E0_1357_9BDF_0246);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_ip = '0; cr_we = 1'b0; cr_wdata = '0;
    refill_en = 1'b0; refill_ip = '0; refill_cr = '0; refill_word = '0;
    refill_keep = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hit();
    t_context();
    t_alias();
    t_invalidate();
    t_bypass();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule